// File: doc/BRIEF.md
# Staged Power-Fail Supervisor

This block sits between three digitized supply comparators and the rest of a battery-backed microcontroller. It turns their flags into a staged power-down and power-up sequence. Each flag is active high and means the supply is below one level. The levels are an early-warning level, the minimum operating level and the level where the part switches over to the backup cell.

A crossing of the warning level raises a one-shot interrupt request while the core keeps running. A crossing of the minimum level puts the core into reset, forces the chip enables and the read/write strobe inactive, and pulls the shared open-drain reset pin low. Other devices on the same reset net can pull that pin low as well, and the supervisor then enters reset too, so that several parts leave reset together. A crossing of the backup level drops an active-low backup flag. When every reset cause has cleared, reset is held for a fixed power-on delay of 21504 clock periods.

Top module: `pfs_supervisor`

## Requirements
- R1: Every threshold flag and the sensed reset pin pass through a two-flop synchroniser. A change on a threshold input reaches the outputs it controls directly after the second rising clock edge.
- R2: When the warning input rises and `warn_en` is high, `pfi_req` goes high after the third rising clock edge following the change.
- R3: With `warn_en` low, a warning crossing raises no request. A warning crossing never puts the core into reset.
- R4: `pfi_req` stays high until `pfi_ack` is seen high at a clock edge, and it is low after that edge. A warning level that stays asserted does not raise the request again.
- R5: `pfi_vector` always presents the interrupt vector address 0x002B.
- R6: While the synchronised minimum-level flag is high, `core_rst`, `ce_inhibit` and `rstpin_drive_low` are all high. Entry shows after the second edge.
- R7: A low level on `rstpin_in` from outside forces `core_rst` high after the second edge. The block does not drive the pin for that cause.
- R8: `backup_n` is low exactly while the synchronised backup-level flag is high.
- R9: Once the minimum-level flag is low and the sensed pin is high, `core_rst` stays high for 21504 more clock edges. With the pin following only this block's own drive, `core_rst` falls after edge N+4 counted from the release of the minimum-level input.
- R10: If any reset cause returns during the power-on delay, the delay starts again in full once that cause clears.
- R11: While `rst_n` is low: `core_rst`, `ce_inhibit` and `rstpin_drive_low` are high, `backup_n` is low and `pfi_req` is low.
- R12: Entry into reset clears a pending `pfi_req` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset of the supervisor logic |
| warn_raw | input | 1 | Supply below warning level (asynchronous) |
| minop_raw | input | 1 | Supply below minimum operating level (asynchronous) |
| bkup_raw | input | 1 | Supply below backup switchover level (asynchronous) |
| warn_en | input | 1 | Enables the power-fail warning interrupt |
| pfi_ack | input | 1 | Acknowledge that clears the interrupt request |
| rstpin_in | input | 1 | Sensed level of the open-drain reset pin |
| pfi_req | output | 1 | Power-fail warning interrupt request |
| pfi_vector | output | 16 | Vector address of the warning interrupt |
| core_rst | output | 1 | Internal reset to the core |
| ce_inhibit | output | 1 | Forces chip enables and read/write strobe inactive high |
| rstpin_drive_low | output | 1 | Enable of the pull-down on the reset pin |
| backup_n | output | 1 | Low while running from the backup cell |

## Verification
The bench raises and drops each comparator input alone. This separates the warning path, which only affects the interrupt, from the minimum-level and backup paths, which affect reset and the backup flag. It then steps through warning followed by minimum-level failure to show that a pending request is lost on reset. A second minimum-level pulse during the power-on delay tells a counter that restarts from one that only pauses. A pull-down applied only from outside shows that the pin's input and output directions are kept apart. The full delay is measured to the exact edge each time.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
   // Synchronised supervisor flags, all active high ("condition present").
   typedef struct packed {
      logic pin_low;   // reset net sensed low
      logic bkup;      // below backup switchover level
      logic minop;     // below minimum operating level
      logic warn;      // below warning level
   } pfs_flags_t;

   localparam int unsigned FLAG_W = $bits(pfs_flags_t);
   // Power-up assumption: every condition present until proven otherwise.
   localparam logic [FLAG_W-1:0] FLAG_RST = '1;
endpackage

// File: rtl/pfs_sync.sv
module pfs_sync #(
   parameter int unsigned            W       = 4,
   parameter int unsigned            STAGES  = 2,
   parameter logic [W-1:0]           RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pfs_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stg[s] <= RST_VAL;
         end else if (s == 0) begin
            stg[s] <= d;
         end else begin
            stg[s] <= stg[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/pfs_por_timer.sv
module pfs_por_timer #(
   parameter int unsigned POR_CYCLES = 21504
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   output logic busy
);
   localparam int unsigned CNT_W = (POR_CYCLES < 2) ? 1 : $clog2(POR_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(POR_CYCLES);

   if (POR_CYCLES == 0) begin : g_no_delay
      assign busy = 1'b0;
   end else begin : g_delay
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt <= CNT_LOAD;
         end else if (hold) begin
            cnt <= CNT_LOAD;
         end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
         end
      end
      assign busy = (cnt != '0);
   end
endmodule

// File: rtl/pfs_pfi_gen.sv
module pfs_pfi_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic warn_s,
   input  logic enable,
   input  logic ack,
   input  logic flush,
   output logic req
);
   logic warn_d;
   logic warn_rise;

   assign warn_rise = warn_s & ~warn_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         warn_d <= 1'b1;
         req    <= 1'b0;
      end else begin
         warn_d <= warn_s;
         if (flush) begin
            req <= 1'b0;
         end else if (warn_rise && enable) begin
            req <= 1'b1;
         end else if (ack) begin
            req <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/pfs_supervisor.sv
module pfs_supervisor #(
   parameter int unsigned        SYNC_STAGES = 2,
   parameter int unsigned        POR_CYCLES  = 21504,
   parameter int unsigned        VEC_W       = 16,
   parameter logic [VEC_W-1:0]   PFI_VECTOR  = VEC_W'(16'h002B)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             warn_raw,
   input  logic             minop_raw,
   input  logic             bkup_raw,
   input  logic             warn_en,
   input  logic             pfi_ack,
   input  logic             rstpin_in,
   output logic             pfi_req,
   output logic [VEC_W-1:0] pfi_vector,
   output logic             core_rst,
   output logic             ce_inhibit,
   output logic             rstpin_drive_low,
   output logic             backup_n
);
   import pfs_pkg::*;

   if (VEC_W < 8) begin : g_bad_vec
      $error("pfs_supervisor: VEC_W must hold the vector address");
   end

   pfs_flags_t raw_flags;
   pfs_flags_t syn_flags;
   logic       rst_cause;
   logic       por_busy;

   assign raw_flags = '{pin_low: ~rstpin_in, bkup: bkup_raw,
                        minop: minop_raw, warn: warn_raw};

   pfs_sync #(
      .W       (FLAG_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (FLAG_RST)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_flags),
      .q     (syn_flags)
   );

   assign rst_cause = syn_flags.minop | syn_flags.pin_low;

   pfs_por_timer #(
      .POR_CYCLES (POR_CYCLES)
   ) u_por (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (rst_cause),
      .busy  (por_busy)
   );

   assign core_rst         = rst_cause | por_busy;
   assign ce_inhibit       = core_rst;
   assign rstpin_drive_low = syn_flags.minop;
   assign backup_n         = ~syn_flags.bkup;
   assign pfi_vector       = PFI_VECTOR;

   pfs_pfi_gen u_pfi (
      .clk    (clk),
      .rst_n  (rst_n),
      .warn_s (syn_flags.warn),
      .enable (warn_en),
      .ack    (pfi_ack),
      .flush  (core_rst),
      .req    (pfi_req)
   );
endmodule

// File: rtl/pfs_supervisor_chk.sv
module pfs_supervisor_chk #(
   parameter int unsigned POR_CYCLES = 21504
) (
   input logic clk,
   input logic rst_n,
   input logic warn_en,
   input logic pfi_ack,
   input logic rstpin_in,
   input logic pfi_req,
   input logic core_rst,
   input logic rstpin_drive_low
);
   localparam int unsigned QW = $clog2(POR_CYCLES + 2) + 1;
   localparam logic [QW-1:0] QMAX = QW'(POR_CYCLES);

   // Cycles in which the reset net has been quiet (not driven, sensed high).
   logic [QW-1:0] quiet;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quiet <= '0;
      end else if (rstpin_drive_low || !rstpin_in) begin
         quiet <= '0;
      end else if (quiet < QMAX) begin
         quiet <= quiet + 1'b1;
      end
   end

   p_drive_forces_rst_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rstpin_drive_low |-> core_rst);

   p_req_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pfi_req) |-> $past(warn_en));

   p_req_drop_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pfi_req) |-> ($past(pfi_ack) || $past(core_rst)));

   p_no_req_in_reset_r12: assert property (@(posedge clk) disable iff (!rst_n)
      core_rst |=> !pfi_req);

   p_release_after_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(core_rst) |-> (quiet >= QMAX));

   p_release_pin_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(core_rst) |-> (rstpin_in && !rstpin_drive_low));
endmodule

bind pfs_supervisor pfs_supervisor_chk #(.POR_CYCLES(POR_CYCLES)) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .warn_en          (warn_en),
   .pfi_ack          (pfi_ack),
   .rstpin_in        (rstpin_in),
   .pfi_req          (pfi_req),
   .core_rst         (core_rst),
   .rstpin_drive_low (rstpin_drive_low)
);

// File: tb/tb_pfs_supervisor.sv
module tb_pfs_supervisor;
   localparam int CLK_PERIOD = 10;
   localparam int N          = 21504;

   logic clk = 1'b0;
   logic rst_n, warn_raw, minop_raw, bkup_raw, warn_en, pfi_ack, ext_pull;
   logic pfi_req, core_rst, ce_inhibit, rstpin_drive_low, backup_n;
   logic [15:0] pfi_vector;
   wire  rstpin = !(rstpin_drive_low || ext_pull);

   always #(CLK_PERIOD/2) clk = ~clk;

   pfs_supervisor dut (
      .clk(clk), .rst_n(rst_n), .warn_raw(warn_raw), .minop_raw(minop_raw),
      .bkup_raw(bkup_raw), .warn_en(warn_en), .pfi_ack(pfi_ack),
      .rstpin_in(rstpin), .pfi_req(pfi_req), .pfi_vector(pfi_vector),
      .core_rst(core_rst), .ce_inhibit(ce_inhibit),
      .rstpin_drive_low(rstpin_drive_low), .backup_n(backup_n)
   );

   typedef struct {
      int    at;
      int    sig;
      logic  val;
      string tag;
   } exp_t;

   exp_t exp_q[$];
   int   cyc = 0;
   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic pick(int sig);
      case (sig)
         0: return core_rst;
         1: return ce_inhibit;
         2: return rstpin_drive_low;
         3: return backup_n;
         default: return pfi_req;
      endcase
   endfunction

   task automatic chk(logic act, logic exp, string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // Driver side: queue an expected value a given number of edges from now.
   task automatic expect_at(int dly, int sig, logic val, string tag);
      exp_q.push_back('{cyc + dly, sig, val, tag});
   endtask

   // Monitor: compare due items away from the active edge.
   always @(negedge clk) begin
      for (int i = exp_q.size() - 1; i >= 0; i--) begin
         if (exp_q[i].at <= cyc) begin
            chk(pick(exp_q[i].sig), exp_q[i].val, exp_q[i].tag);
            exp_q.delete(i);
         end
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
      #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
   end

   initial begin
      rst_n = 0; warn_raw = 0; minop_raw = 0; bkup_raw = 0;
      warn_en = 1; pfi_ack = 0; ext_pull = 0;
      step(3);
      // R11 reset state
      chk(core_rst, 1'b1, "R11 core_rst");
      chk(ce_inhibit, 1'b1, "R11 ce_inhibit");
      chk(rstpin_drive_low, 1'b1, "R11 drive_low");
      chk(backup_n, 1'b0, "R11 backup_n");
      chk(pfi_req, 1'b0, "R11 pfi_req");
      rst_n = 1;
      expect_at(2, 3, 1'b1, "R1 backup_n clears");
      expect_at(N + 3, 0, 1'b1, "R9 power-up hold");
      expect_at(N + 4, 0, 1'b0, "R9 power-up release");
      drain();
      step(3);

      // R2 / R5: enabled warning
      chk(pfi_vector == 16'h002B, 1'b1, "R5 vector");
      warn_raw = 1;
      expect_at(2, 4, 1'b0, "R2 not yet");
      expect_at(3, 4, 1'b1, "R2 request");
      expect_at(3, 0, 1'b0, "R3 core keeps running");
      drain();
      step(4);
      chk(pfi_req, 1'b1, "R4 held until ack");
      pfi_ack = 1;
      expect_at(1, 4, 1'b0, "R4 ack clears");
      step(1);
      pfi_ack = 0;
      expect_at(5, 4, 1'b0, "R4 no re-raise");
      drain();
      warn_raw = 0;
      step(5);

      // R3: disabled warning
      warn_en = 0;
      warn_raw = 1;
      expect_at(3, 4, 1'b0, "R3 disabled");
      expect_at(6, 4, 1'b0, "R3 disabled later");
      expect_at(6, 0, 1'b0, "R3 no reset");
      drain();
      warn_raw = 0;
      warn_en = 1;
      step(5);

      // R8 / R1: backup level
      bkup_raw = 1;
      expect_at(1, 3, 1'b1, "R1 backup latency");
      expect_at(2, 3, 1'b0, "R8 backup active");
      drain();
      bkup_raw = 0;
      expect_at(2, 3, 1'b1, "R8 backup left");
      drain();
      step(3);

      // R6 / R12: warning then minimum-level failure
      warn_raw = 1;
      step(4);
      chk(pfi_req, 1'b1, "R12 request pending");
      minop_raw = 1;
      expect_at(1, 0, 1'b0, "R6 latency");
      expect_at(2, 0, 1'b1, "R6 core_rst");
      expect_at(2, 1, 1'b1, "R6 ce_inhibit");
      expect_at(2, 2, 1'b1, "R6 pin driven");
      expect_at(2, 4, 1'b1, "R12 before flush");
      expect_at(3, 4, 1'b0, "R12 flushed");
      drain();
      step(3);
      minop_raw = 0;
      warn_raw = 0;
      expect_at(N + 3, 0, 1'b1, "R9 hold");
      expect_at(N + 4, 0, 1'b0, "R9 release");
      drain();
      step(3);

      // R10: restart of the delay
      minop_raw = 1;
      step(10);
      minop_raw = 0;
      expect_at(N + 3, 0, 1'b1, "R10 still held");
      step(1000);
      minop_raw = 1;
      step(3);
      minop_raw = 0;
      expect_at(N + 3, 0, 1'b1, "R10 restarted hold");
      expect_at(N + 4, 0, 1'b0, "R10 restarted release");
      drain();
      step(3);

      // R7: external pull-down only
      ext_pull = 1;
      expect_at(2, 0, 1'b1, "R7 external reset");
      expect_at(2, 2, 1'b0, "R7 not driven");
      drain();
      step(3);
      ext_pull = 0;
      expect_at(N + 1, 0, 1'b1, "R7 hold");
      expect_at(N + 2, 0, 1'b0, "R7 release");
      drain();
      step(2);
      finish_run();
   end
endmodule